// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a synchronous host and an external asynchronous static RAM that holds 512K words of 32 bits, built as four 8-bit banks sharing one 19-bit word address. The host issues one request at a time through a valid/ready handshake. Each request carries a read/write flag, a word address, write data and a 4-bit byte mask. The block answers every request with a one-cycle completion pulse, and for reads the pulse comes with the returned data.

On the memory side the controller sequences the address, the active-low bank selects, the write strobes and the output enable. Every memory-side output comes straight from a register. The data bus is split into an output value, a drive enable and an input, so the pad tri-state sits outside the block. Each phase length is computed at elaboration from a nanosecond limit and the clock period, and is at least one cycle.

A parameter chooses between two byte-selection styles. In the shared-strobe style, a byte is picked by asserting only its bank select. In the per-lane style, all four bank selects are asserted and the mask gates four separate write strobes.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0. All bank selects, both strobe styles and the output enable are high, and `mem_dq_oe` is 0.
- R2: Byte lane i covers data bits 8i+7..8i, and mask bit i selects it. With PER_LANE_WE=0, a write asserts `mem_cs_n[i]` low only for lanes whose mask bit is 1, while `mem_we_n` is low. Bytes whose mask bit is 0 keep their old value, and that includes a write with an all-zero mask.
- R3: With PER_LANE_WE=1, every `mem_cs_n` bit is low during an access. `mem_lane_we_n[i]` pulses low only for lanes whose mask bit is 1. The unused strobe style stays high in both modes.
- R4: A read holds `mem_oe_n` low with the write strobes high and the same lane selection as a write. In `rsp_rdata`, a lane whose mask bit is 1 carries the bus byte captured on the last access cycle, and a lane whose mask bit is 0 reads as zero.
- R5: Each phase lasts max(1, ceil(limit/CLK_NS)) cycles. The strobe phase uses the larger of the strobe-width limit and the data-setup limit. `rsp_valid` rises setup+strobe+hold cycles after a write is accepted, or access cycles after a read is accepted, counted from the cycle after acceptance, plus one.
- R6: If a request's direction differs from the previous request's, the controller inserts the turnaround count of cycles with every strobe high before the new access. If the direction is the same, no such cycles are added.
- R7: `mem_dq_oe` is high only during the setup, strobe and hold phases of a write. It is never high while `mem_oe_n` is low, and a write strobe is never low unless `mem_dq_oe` is high.
- R8: `req_ready` falls in the cycle after a request is accepted and stays low until the cycle in which `rsp_valid` pulses. `rsp_valid` is high for exactly one cycle.
- R9: While any bank select is low, `mem_addr` equals the accepted request address and does not change.
- R10: Every write strobe rises at least one cycle before the bank selects are released (address hold).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_mask | input | LANES | Byte-lane mask, bit i = bits 8i+7..8i |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, unmasked lanes zero |
| mem_addr | output | ADDR_W | Memory word address |
| mem_cs_n | output | LANES | Active-low bank selects |
| mem_we_n | output | 1 | Active-low shared write strobe |
| mem_lane_we_n | output | LANES | Active-low per-lane write strobes |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | DATA_W | Data driven toward memory |
| mem_dq_oe | output | 1 | Drive enable for the data pads |
| mem_dq_in | input | DATA_W | Data returned from the pads |

## Verification
The assertions assume that CLK_NS matches the real clock period and that the host changes a request only while `req_valid` is low. They also assume that `mem_dq_in` is driven only by a memory that obeys select, output-enable and strobe levels. The bench keeps to these limits in three ways. It raises `req_valid` only at a falling edge where `req_ready` is high and drops it after one accept edge. Its bank model drives a lane only while that lane is selected for a read and otherwise returns a fixed filler byte, so masked-off lanes show up if they leak. Two instances, one per strobe style, see identical random and directed traffic.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_TURN   = 3'd1,
      PH_SETUP  = 3'd2,
      PH_STROBE = 3'd3,
      PH_HOLD   = 3'd4,
      PH_ACCESS = 3'd5
   } phase_t;

   // cycles needed to cover limit_ns at clk_ns per cycle, never below one
   function automatic int unsigned wait_cycles(input int unsigned limit_ns,
                                               input int unsigned clk_ns);
      int unsigned c;
      c = (limit_ns + clk_ns - 1) / clk_ns;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_wait_cnt.sv
module sram_wait_cnt #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             last
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign last = (cnt == '0);
endmodule

// File: rtl/sram_phase_fsm.sv
module sram_phase_fsm
   import sram_ctrl_pkg::*;
#(
   parameter int unsigned N_SETUP  = 1,
   parameter int unsigned N_STROBE = 1,
   parameter int unsigned N_HOLD   = 1,
   parameter int unsigned N_ACCESS = 1,
   parameter int unsigned N_TURN   = 1,
   parameter int          CNT_W    = 2
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   req_valid,
   input  logic   req_write,
   output phase_t phase_q,
   output phase_t phase_d,
   output logic   op_wr_d,
   output logic   accept,
   output logic   capture,
   output logic   wr_done
);
   localparam logic [CNT_W-1:0] L_SETUP  = CNT_W'(N_SETUP - 1);
   localparam logic [CNT_W-1:0] L_STROBE = CNT_W'(N_STROBE - 1);
   localparam logic [CNT_W-1:0] L_HOLD   = CNT_W'(N_HOLD - 1);
   localparam logic [CNT_W-1:0] L_ACCESS = CNT_W'(N_ACCESS - 1);
   localparam logic [CNT_W-1:0] L_TURN   = CNT_W'(N_TURN - 1);

   logic             op_wr_q;
   logic             have_prev_q;
   logic             load;
   logic [CNT_W-1:0] load_val;
   logic             last;
   logic             need_turn;

   sram_wait_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .last     (last)
   );

   assign need_turn = have_prev_q && (op_wr_q != req_write);
   assign op_wr_d   = accept ? req_write : op_wr_q;

   always_comb begin
      phase_d  = phase_q;
      load     = 1'b0;
      load_val = '0;
      accept   = 1'b0;
      capture  = 1'b0;
      wr_done  = 1'b0;
      unique case (phase_q)
         PH_IDLE: begin
            if (req_valid) begin
               accept = 1'b1;
               load   = 1'b1;
               if (need_turn) begin
                  phase_d  = PH_TURN;
                  load_val = L_TURN;
               end else if (req_write) begin
                  phase_d  = PH_SETUP;
                  load_val = L_SETUP;
               end else begin
                  phase_d  = PH_ACCESS;
                  load_val = L_ACCESS;
               end
            end
         end
         PH_TURN: begin
            if (last) begin
               load = 1'b1;
               if (op_wr_q) begin
                  phase_d  = PH_SETUP;
                  load_val = L_SETUP;
               end else begin
                  phase_d  = PH_ACCESS;
                  load_val = L_ACCESS;
               end
            end
         end
         PH_SETUP: begin
            if (last) begin
               phase_d  = PH_STROBE;
               load     = 1'b1;
               load_val = L_STROBE;
            end
         end
         PH_STROBE: begin
            if (last) begin
               phase_d  = PH_HOLD;
               load     = 1'b1;
               load_val = L_HOLD;
            end
         end
         PH_HOLD: begin
            if (last) begin
               phase_d = PH_IDLE;
               wr_done = 1'b1;
            end
         end
         PH_ACCESS: begin
            if (last) begin
               phase_d = PH_IDLE;
               capture = 1'b1;
            end
         end
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q     <= PH_IDLE;
         op_wr_q     <= 1'b0;
         have_prev_q <= 1'b0;
      end else begin
         phase_q <= phase_d;
         if (accept) begin
            op_wr_q     <= req_write;
            have_prev_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/sram_lane_drive.sv
module sram_lane_drive
   import sram_ctrl_pkg::*;
#(
   parameter int LANES       = 4,
   parameter bit PER_LANE_WE = 1'b0
) (
   input  phase_t           phase_d,
   input  logic [LANES-1:0] mask_d,
   output logic [LANES-1:0] cs_n_d,
   output logic             we_n_d,
   output logic [LANES-1:0] lane_we_n_d,
   output logic             oe_n_d,
   output logic             dq_oe_d
);
   logic active;
   logic strobe;

   assign active  = (phase_d == PH_SETUP) || (phase_d == PH_STROBE) ||
                    (phase_d == PH_HOLD)  || (phase_d == PH_ACCESS);
   assign strobe  = (phase_d == PH_STROBE);
   assign oe_n_d  = !(phase_d == PH_ACCESS);
   assign dq_oe_d = (phase_d == PH_SETUP) || (phase_d == PH_STROBE) ||
                    (phase_d == PH_HOLD);

   generate
      if (PER_LANE_WE) begin : g_lane_strobe
         assign we_n_d = 1'b1;
         for (genvar i = 0; i < LANES; i++) begin : g_lane
            assign cs_n_d[i]      = !active;
            assign lane_we_n_d[i] = !(strobe && mask_d[i]);
         end
      end else begin : g_shared_strobe
         assign we_n_d = !strobe;
         for (genvar i = 0; i < LANES; i++) begin : g_lane
            assign cs_n_d[i]      = !(active && mask_d[i]);
            assign lane_we_n_d[i] = 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int          ADDR_W      = 19,
   parameter int          LANES       = 4,
   parameter int          DATA_W      = 32,
   parameter bit          PER_LANE_WE = 1'b0,
   parameter int unsigned CLK_NS      = 10,
   parameter int unsigned T_SETUP_NS  = 2,
   parameter int unsigned T_STROBE_NS = 15,
   parameter int unsigned T_DSETUP_NS = 12,
   parameter int unsigned T_HOLD_NS   = 1,
   parameter int unsigned T_ACCESS_NS = 17,
   parameter int unsigned T_TURN_NS   = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_mask,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [LANES-1:0]  mem_cs_n,
   output logic              mem_we_n,
   output logic [LANES-1:0]  mem_lane_we_n,
   output logic              mem_oe_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);
   localparam int unsigned N_SETUP  = wait_cycles(T_SETUP_NS, CLK_NS);
   localparam int unsigned N_STROBE = max_u(wait_cycles(T_STROBE_NS, CLK_NS),
                                            wait_cycles(T_DSETUP_NS, CLK_NS));
   localparam int unsigned N_HOLD   = wait_cycles(T_HOLD_NS, CLK_NS);
   localparam int unsigned N_ACCESS = wait_cycles(T_ACCESS_NS, CLK_NS);
   localparam int unsigned N_TURN   = wait_cycles(T_TURN_NS, CLK_NS);
   localparam int unsigned N_MAX    = max_u(max_u(max_u(N_SETUP, N_STROBE),
                                                  max_u(N_HOLD, N_ACCESS)), N_TURN);
   localparam int          CNT_W    = $clog2(N_MAX + 1);
   localparam int          LANE_W   = DATA_W / LANES;

   generate
      if (CLK_NS == 0) begin : g_bad_clk
         $error("CLK_NS must be non-zero");
      end
      if (LANE_W != 8 || DATA_W != LANES * 8) begin : g_bad_lanes
         $error("DATA_W must be eight bits per lane");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("ADDR_W must be positive");
      end
      if (N_TURN > 250) begin : g_bad_turn
         $error("turnaround count too large");
      end
   endgenerate

   phase_t              phase_q;
   phase_t              phase_d;
   logic                op_wr_d;
   logic                accept;
   logic                capture;
   logic                wr_done;

   logic [ADDR_W-1:0]   op_addr_q;
   logic [DATA_W-1:0]   op_wdata_q;
   logic [LANES-1:0]    op_mask_q;
   logic [ADDR_W-1:0]   addr_d;
   logic [DATA_W-1:0]   wdata_d;
   logic [LANES-1:0]    mask_d;

   logic [LANES-1:0]    cs_n_d;
   logic                we_n_d;
   logic [LANES-1:0]    lane_we_n_d;
   logic                oe_n_d;
   logic                dq_oe_d;
   logic [DATA_W-1:0]   rdata_d;

   sram_phase_fsm #(
      .N_SETUP  (N_SETUP),
      .N_STROBE (N_STROBE),
      .N_HOLD   (N_HOLD),
      .N_ACCESS (N_ACCESS),
      .N_TURN   (N_TURN),
      .CNT_W    (CNT_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .phase_q   (phase_q),
      .phase_d   (phase_d),
      .op_wr_d   (op_wr_d),
      .accept    (accept),
      .capture   (capture),
      .wr_done   (wr_done)
   );

   assign addr_d  = accept ? req_addr  : op_addr_q;
   assign wdata_d = accept ? req_wdata : op_wdata_q;
   assign mask_d  = accept ? req_mask  : op_mask_q;

   sram_lane_drive #(
      .LANES       (LANES),
      .PER_LANE_WE (PER_LANE_WE)
   ) u_drive (
      .phase_d     (phase_d),
      .mask_d      (mask_d),
      .cs_n_d      (cs_n_d),
      .we_n_d      (we_n_d),
      .lane_we_n_d (lane_we_n_d),
      .oe_n_d      (oe_n_d),
      .dq_oe_d     (dq_oe_d)
   );

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_rd_lane
         assign rdata_d[i*8 +: 8] = op_mask_q[i] ? mem_dq_in[i*8 +: 8] : 8'h00;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_addr_q  <= '0;
         op_wdata_q <= '0;
         op_mask_q  <= '0;
      end else if (accept) begin
         op_addr_q  <= req_addr;
         op_wdata_q <= req_wdata;
         op_mask_q  <= req_mask;
      end
   end

   // registered pin drivers, so the asynchronous memory never sees decode glitches
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr      <= '0;
         mem_cs_n      <= '1;
         mem_we_n      <= 1'b1;
         mem_lane_we_n <= '1;
         mem_oe_n      <= 1'b1;
         mem_dq_out    <= '0;
         mem_dq_oe     <= 1'b0;
      end else begin
         mem_addr      <= addr_d;
         mem_cs_n      <= cs_n_d;
         mem_we_n      <= we_n_d;
         mem_lane_we_n <= lane_we_n_d;
         mem_oe_n      <= oe_n_d;
         mem_dq_out    <= op_wr_d ? wdata_d : '0;
         mem_dq_oe     <= dq_oe_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= capture || wr_done;
         if (capture) begin
            rsp_rdata <= rdata_d;
         end
      end
   end

   assign req_ready = (phase_q == PH_IDLE);
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
   parameter int          ADDR_W      = 19,
   parameter int          LANES       = 4,
   parameter bit          PER_LANE_WE = 1'b0,
   parameter int unsigned N_TURN      = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [LANES-1:0]  mem_cs_n,
   input logic              mem_we_n,
   input logic [LANES-1:0]  mem_lane_we_n,
   input logic              mem_oe_n,
   input logic              mem_dq_oe
);
   logic       cs_low;
   logic       we_low;
   logic [7:0] oe_gap;

   assign cs_low = !(&mem_cs_n);
   assign we_low = !mem_we_n || !(&mem_lane_we_n);

   // cycles since the memory was last allowed to drive the bus
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_gap <= 8'hFF;
      end else if (!mem_oe_n) begin
         oe_gap <= 8'h00;
      end else if (oe_gap != 8'hFF) begin
         oe_gap <= oe_gap + 8'h01;
      end
   end

   AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_dq_oe && !mem_oe_n)); // R7
   AST_STROBE_NEEDS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      we_low |-> mem_dq_oe); // R7
   AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_dq_oe) |-> (oe_gap >= 8'(N_TURN))); // R6
   AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready); // R8
   AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R8
   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_low && $past(cs_low)) |-> $stable(mem_addr)); // R9
   AST_STROBE_IN_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      (we_low && (&mem_lane_we_n == 1'b0)) |-> cs_low); // R3
   AST_HOLD_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(we_low) && !we_low && $past(cs_low)) |-> cs_low); // R10
   AST_ONE_STROBE_STYLE: assert property (@(posedge clk) disable iff (!rst_n)
      (PER_LANE_WE ? mem_we_n : (&mem_lane_we_n))); // R3
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
   .ADDR_W      (ADDR_W),
   .LANES       (LANES),
   .PER_LANE_WE (PER_LANE_WE),
   .N_TURN      (N_TURN)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .rsp_valid     (rsp_valid),
   .mem_addr      (mem_addr),
   .mem_cs_n      (mem_cs_n),
   .mem_we_n      (mem_we_n),
   .mem_lane_we_n (mem_lane_we_n),
   .mem_oe_n      (mem_oe_n),
   .mem_dq_oe     (mem_dq_oe)
);

// File: tb/sram_lane_ctrl_bench.sv
module sram_bench_mem (
   input  logic        clk,
   input  logic [18:0] addr,
   input  logic [3:0]  cs_n,
   input  logic [3:0]  we_n,
   input  logic        oe_n,
   input  logic [31:0] wr_data,
   input  logic        wr_drive,
   output logic [31:0] rd_data
);
   logic [31:0] store [64];

   initial begin
      for (int i = 0; i < 64; i++) store[i] = 32'h0;
   end

   always @(posedge clk) begin
      for (int i = 0; i < 4; i++) begin
         if (!cs_n[i] && !we_n[i])
            store[addr[5:0]][i*8 +: 8] <= wr_drive ? wr_data[i*8 +: 8] : 8'h00;
      end
   end

   always_comb begin
      for (int i = 0; i < 4; i++) begin
         rd_data[i*8 +: 8] = (!cs_n[i] && !oe_n && we_n[i]) ?
                             store[addr[5:0]][i*8 +: 8] : 8'hA5;
      end
   end
endmodule

module sram_lane_ctrl_bench;
   localparam int unsigned CLK_NS = 20;
   localparam int unsigned TS_NS = 2, TW_NS = 25, TD_NS = 20, TH_NS = 1;
   localparam int unsigned TA_NS = 55, TT_NS = 20;

   function automatic int cyc(input int unsigned lim);
      int unsigned c;
      c = (lim + CLK_NS - 1) / CLK_NS;
      return (c < 1) ? 1 : int'(c);
   endfunction

   localparam int NS = 1, NW = 2, NH = 1, NA = 3, NT = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = !clk;

   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [18:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [3:0]  req_mask = '0;

   logic        rdy_s, rdy_p, rv_s, rv_p, we_s, we_p, oe_s, oe_p, dqoe_s, dqoe_p;
   logic [31:0] rd_s, rd_p, dqo_s, dqo_p, dqi_s, dqi_p;
   logic [18:0] ma_s, ma_p;
   logic [3:0]  cs_s, cs_p, lwe_s, lwe_p;

   sram_lane_ctrl #(.PER_LANE_WE(1'b0), .CLK_NS(CLK_NS), .T_SETUP_NS(TS_NS),
      .T_STROBE_NS(TW_NS), .T_DSETUP_NS(TD_NS), .T_HOLD_NS(TH_NS),
      .T_ACCESS_NS(TA_NS), .T_TURN_NS(TT_NS)) u_sram_lane_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_s),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_mask(req_mask), .rsp_valid(rv_s), .rsp_rdata(rd_s), .mem_addr(ma_s),
      .mem_cs_n(cs_s), .mem_we_n(we_s), .mem_lane_we_n(lwe_s), .mem_oe_n(oe_s),
      .mem_dq_out(dqo_s), .mem_dq_oe(dqoe_s), .mem_dq_in(dqi_s));

   sram_lane_ctrl #(.PER_LANE_WE(1'b1), .CLK_NS(CLK_NS), .T_SETUP_NS(TS_NS),
      .T_STROBE_NS(TW_NS), .T_DSETUP_NS(TD_NS), .T_HOLD_NS(TH_NS),
      .T_ACCESS_NS(TA_NS), .T_TURN_NS(TT_NS)) u_sram_lane_ctrl_pl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_p),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_mask(req_mask), .rsp_valid(rv_p), .rsp_rdata(rd_p), .mem_addr(ma_p),
      .mem_cs_n(cs_p), .mem_we_n(we_p), .mem_lane_we_n(lwe_p), .mem_oe_n(oe_p),
      .mem_dq_out(dqo_p), .mem_dq_oe(dqoe_p), .mem_dq_in(dqi_p));

   sram_bench_mem u_mem_s (.clk(clk), .addr(ma_s), .cs_n(cs_s), .we_n({4{we_s}}),
      .oe_n(oe_s), .wr_data(dqo_s), .wr_drive(dqoe_s), .rd_data(dqi_s));
   sram_bench_mem u_mem_p (.clk(clk), .addr(ma_p), .cs_n(cs_p), .we_n(lwe_p),
      .oe_n(oe_p), .wr_data(dqo_p), .wr_drive(dqoe_p), .rd_data(dqi_p));

   int          n_checks = 0;
   int          n_err = 0;
   bit          finished = 1'b0;
   bit          have_prev = 1'b0;
   bit          prev_wr = 1'b0;
   logic [31:0] ref_mem [64];

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] expect_read(input logic [18:0] a, input logic [3:0] m);
      logic [31:0] r;
      for (int i = 0; i < 4; i++) r[i*8 +: 8] = m[i] ? ref_mem[a[5:0]][i*8 +: 8] : 8'h00;
      return r;
   endfunction

   function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                         input logic [3:0] m);
      logic [31:0] r;
      for (int i = 0; i < 4; i++) r[i*8 +: 8] = m[i] ? nw[i*8 +: 8] : old[i*8 +: 8];
      return r;
   endfunction

   task automatic do_op(input bit wr, input logic [18:0] a, input logic [31:0] d,
                        input logic [3:0] m);
      int  k, lat, wcs, wcp;
      bit  turn, rdy_bad, addr_bad, lane_bad, fight_bad, hold_bad, pw_s, pw_p;
      @(negedge clk);
      check(rdy_s && rdy_p && !rv_s && !rv_p, "R8 idle ready / single pulse",
            {rdy_s, rdy_p, rv_s, rv_p}, 32'hC);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      req_wdata = $urandom;
      turn = have_prev && (prev_wr != wr);
      lat  = (wr ? (NS + NW + NH) : NA) + (turn ? NT : 0) + 1;
      k = 1; wcs = 0; wcp = 0;
      rdy_bad = 0; addr_bad = 0; lane_bad = 0; fight_bad = 0; hold_bad = 0;
      pw_s = 0; pw_p = 0;
      while (!rv_s && k < 40) begin
         if (rdy_s || rdy_p) rdy_bad = 1;
         if ((dqoe_s && !oe_s) || (dqoe_p && !oe_p)) fight_bad = 1;
         if (!wr && (dqoe_s || dqoe_p)) fight_bad = 1;
         if ((cs_s != 4'hF && ma_s != a) || (cs_p != 4'hF && ma_p != a)) addr_bad = 1;
         if (!we_s) begin
            wcs++;
            if (cs_s != ~m || !dqoe_s) lane_bad = 1;
         end
         if (lwe_p != 4'hF) begin
            wcp++;
            if (cs_p != 4'h0 || lwe_p != ~m || !dqoe_p) lane_bad = 1;
         end
         if (!lwe_s[0] || !we_p) lane_bad = 1;
         if (!oe_s && (cs_s != ~m || !we_s)) lane_bad = 1;
         if (!oe_p && (cs_p != 4'h0 || lwe_p != 4'hF)) lane_bad = 1;
         if (pw_s && we_s && m != 4'h0 && cs_s == 4'hF) hold_bad = 1;
         if (pw_p && (&lwe_p) && cs_p == 4'hF) hold_bad = 1;
         pw_s = !we_s; pw_p = !(&lwe_p);
         @(negedge clk);
         k++;
      end
      check(k == lat, turn ? "R6 turnaround latency" : "R5 phase latency", k, lat);
      check(rv_s == rv_p, "R5 both styles complete together", rv_p, rv_s);
      check(!rdy_bad && rdy_s, "R8 ready low while busy", rdy_bad, 0);
      check(!fight_bad, "R7 bus drive only in write phases", fight_bad, 0);
      check(!addr_bad, "R9 address stable and correct", addr_bad, 0);
      check(!lane_bad, wr ? "R2 R3 write lane strobes" : "R4 read lane selects",
            lane_bad, 0);
      check(!hold_bad, "R10 select held after strobe", hold_bad, 0);
      if (wr) begin
         check(wcs == NW, "R5 shared strobe width", wcs, NW);
         check(wcp == ((m != 0) ? NW : 0), "R3 per-lane strobe width", wcp,
               (m != 0) ? NW : 0);
         ref_mem[a[5:0]] = merge(ref_mem[a[5:0]], d, m);
      end else begin
         check(rd_s == expect_read(a, m), "R2 R4 read data shared style", rd_s,
               expect_read(a, m));
         check(rd_p == expect_read(a, m), "R3 R4 read data per-lane style", rd_p,
               expect_read(a, m));
      end
      have_prev = 1'b1;
      prev_wr = wr;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_err++;
         $display("FAIL watchdog: run did not complete actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_err, n_checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 64; i++) ref_mem[i] = 32'h0;
      if (cyc(TS_NS) != NS || cyc(TD_NS) > NW || cyc(TW_NS) != NW || cyc(TH_NS) != NH ||
          cyc(TA_NS) != NA || cyc(TT_NS) != NT)
         $display("bench timing constants disagree with limits");
      repeat (3) @(negedge clk);
      // R1: reset state
      check(rdy_s && rdy_p && !rv_s && !rv_p, "R1 reset handshake", {rdy_s, rv_s}, 32'h2);
      check(cs_s == 4'hF && cs_p == 4'hF && we_s && we_p && lwe_s == 4'hF &&
            lwe_p == 4'hF && oe_s && oe_p && !dqoe_s && !dqoe_p,
            "R1 reset memory pins", {cs_s, cs_p, lwe_s, lwe_p}, 32'hFFFF);
      rst_n = 1'b1;
      // directed corners
      do_op(1, 19'h00000, 32'h11223344, 4'hF);
      do_op(1, 19'h7FFFF, 32'hCAFEF00D, 4'hF);
      do_op(1, 19'h00000, 32'hAABBCCDD, 4'h0);   // R2 empty mask
      do_op(0, 19'h00000, 32'h0, 4'hF);
      do_op(0, 19'h7FFFF, 32'h0, 4'hF);          // back-to-back reads, R6 none
      do_op(1, 19'h00001, 32'h55667788, 4'b0101);
      do_op(0, 19'h00001, 32'h0, 4'hF);
      do_op(0, 19'h7FFFF, 32'h0, 4'b1010);
      do_op(0, 19'h00000, 32'h0, 4'h0);
      do_op(1, 19'h00002, 32'h01020304, 4'b1000);
      do_op(1, 19'h00002, 32'h0A0B0C0D, 4'b0001);
      do_op(0, 19'h00002, 32'h0, 4'hF);
      // constrained random traffic
      for (int n = 0; n < 600; n++) begin
         logic [18:0] a;
         a = {13'($urandom), 6'($urandom % 24)};
         do_op(1'($urandom), a, $urandom, 4'($urandom));
      end
      for (int i = 0; i < 24; i++) do_op(0, 19'(i), 32'h0, 4'hF);
      @(negedge clk);
      check(!rv_s && !rv_p && rdy_s && rdy_p, "R8 final pulse ended", {rv_s, rv_p}, 0);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end
endmodule